// File: doc/BRIEF.md
# Wavetable Voice Oscillator

One voice of a wavetable sound generator. The voice keeps a 32-entry table of signed 8-bit samples, a 12-bit pitch, a 4-bit volume and a frequency down-counter. The counter sets how many ticks pass between pointer steps. The read pointer walks the table modulo 32. On every tick the voice registers the sample at the new pointer position, scaled by the volume. While the enable input is low, that registered sample is zero.

Three mode inputs come from a test register shared by all voices. Two of them split the counter: one takes the carry from the low byte alone, the other decrements the low byte and the high nibble separately and takes the carry from the nibble. The third makes every pitch write clear the read pointer. A mixer that sums several voices, and the host decode that routes table writes to a voice, sit outside this block.

Top module: `wave_voice`

## Requirements
- R1: After reset, the pointer `pos_o` is 0 and `sample_o` is 0. Pitch, volume, counter and every table entry are also 0.
- R2: A pitch-low write loads pitch bits 7:0 from `pitch_data_i`. A pitch-high write loads pitch bits 11:8 from `pitch_data_i[3:0]` and ignores the upper data nibble.
- R3: With both frequency modes off and pitch P >= 9, each tick decrements the 12-bit counter with wraparound. When the counter held 0 before the decrement, the pointer steps by 1 modulo 32 and the counter reloads with P. The first tick after reset therefore steps the pointer, and after that it steps once every P+1 ticks.
- R4: While pitch is below 9, ticks change neither the counter nor the pointer.
- R5: With `freq8_i`=1 and `freq4_i`=0, the carry fires when the low 8 bits of the counter were 0 before the tick. For P=0x105 the pointer steps every 6 ticks.
- R6: With `freq4_i`=1 and `freq8_i`=0, the low byte and the high nibble each decrement with their own wraparound, and the carry fires when the high nibble was 0. For P=0x203 the pointer steps every 3 ticks.
- R7: With both modes set, the split decrement of R6 applies and the carry rule of R5 decides. For P=0x203 the pointer steps every 4 ticks.
- R8: On a tick with `enable_i`=1, `sample_o` becomes (table[new pointer] * volume) arithmetically shifted right by 4. `sample_o` holds its value between ticks.
- R9: On a tick with `enable_i`=0, `sample_o` becomes 0.
- R10: While `rst_pos_i`=1, a write to either pitch byte clears the pointer to 0. While `rst_pos_i`=0, a pitch write leaves the pointer unchanged.
- R11: A table write stores `wave_data_i` at entry `wave_addr_i`. Later ticks that land on that entry output the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator step strobe |
| pitch_lo_we_i | input | 1 | Write pitch bits 7:0 |
| pitch_hi_we_i | input | 1 | Write pitch bits 11:8 |
| pitch_data_i | input | 8 | Pitch write data |
| vol_we_i | input | 1 | Volume write strobe |
| vol_data_i | input | 4 | Volume data |
| enable_i | input | 1 | Output enable |
| freq8_i | input | 1 | Carry from low byte only |
| freq4_i | input | 1 | Split decrement, carry from high nibble |
| rst_pos_i | input | 1 | Pitch writes clear pointer |
| wave_we_i | input | 1 | Table write strobe |
| wave_addr_i | input | 5 | Table write index |
| wave_data_i | input | 8 | Signed sample to store |
| sample_o | output | 8 | Signed scaled sample |
| pos_o | output | 5 | Current read pointer |

## Verification
The split-counter modes are the hardest to reach from the ports. Their effect shows only as a changed step period, and only with a pitch whose low byte and high nibble are both nonzero. The bench resets before each vector, programs a pitch such as 0x203 or 0x105, runs a known number of ticks and compares the pointer against counts worked out by hand for each carry rule. The same vectors also cover pointer wraparound after 321 ticks and pitch writes that use only the low nibble of the high byte.

// File: rtl/wv_pkg.sv
package wv_pkg;
  localparam int unsigned WAVE_DEPTH = 32;
  localparam int unsigned SAMPLE_W   = 8;
  localparam int unsigned PITCH_W    = 12;
  localparam int unsigned PITCH_LO_W = 8;
  localparam int unsigned VOL_W      = 4;
  localparam int unsigned MIN_PITCH  = 9;
  localparam int unsigned PTR_W      = $clog2(WAVE_DEPTH);

  typedef struct packed {
    logic freq8;
    logic freq4;
    logic rst_pos;
  } wv_mode_t;
endpackage

// File: rtl/wv_table.sv
module wv_table #(
  parameter int unsigned DEPTH = wv_pkg::WAVE_DEPTH,
  parameter int unsigned W     = wv_pkg::SAMPLE_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wv_counter.sv
module wv_counter #(
  parameter int unsigned PITCH_W   = wv_pkg::PITCH_W,
  parameter int unsigned LO_W      = wv_pkg::PITCH_LO_W,
  parameter int unsigned PTR_W     = wv_pkg::PTR_W,
  parameter int unsigned MIN_PITCH = wv_pkg::MIN_PITCH,
  localparam int unsigned HI_W     = PITCH_W - LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pitch_lo_we_i,
  input  logic             pitch_hi_we_i,
  input  logic [LO_W-1:0]  pitch_data_i,
  input  wv_pkg::wv_mode_t mode_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_nxt_o
);
  logic [PITCH_W-1:0] pitch_q, cnt_q, cnt_dec, cnt_nxt;
  logic [PTR_W-1:0]   ptr_q, ptr_nxt;
  logic               run, carry, pwr;

  assign pwr = pitch_lo_we_i | pitch_hi_we_i;
  assign run = tick_i && (pitch_q >= PITCH_W'(MIN_PITCH));

  always_comb begin
    if (mode_i.freq4) begin
      cnt_dec[LO_W-1:0]       = cnt_q[LO_W-1:0] - 1'b1;
      cnt_dec[PITCH_W-1:LO_W] = cnt_q[PITCH_W-1:LO_W] - 1'b1;
    end else begin
      cnt_dec = cnt_q - 1'b1;
    end
    // low-byte rule takes priority over nibble rule
    if (mode_i.freq8)      carry = (cnt_q[LO_W-1:0] == '0);
    else if (mode_i.freq4) carry = (cnt_q[PITCH_W-1:LO_W] == '0);
    else                   carry = (cnt_q == '0);

    cnt_nxt = cnt_q;
    ptr_nxt = ptr_q;
    if (run) begin
      cnt_nxt = carry ? pitch_q : cnt_dec;
      if (carry) ptr_nxt = ptr_q + 1'b1;
    end
    if (pwr && mode_i.rst_pos) ptr_nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pitch_q <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      ptr_q <= ptr_nxt;
      if (pitch_lo_we_i) pitch_q[LO_W-1:0]       <= pitch_data_i;
      if (pitch_hi_we_i) pitch_q[PITCH_W-1:LO_W] <= pitch_data_i[HI_W-1:0];
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_nxt_o = ptr_nxt;

  // R4: low pitch freezes the pointer
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pitch_q < PITCH_W'(MIN_PITCH) && !pwr) |=> (ptr_q == $past(ptr_q)));
  // R10: pitch write with reset-position mode clears pointer
  a_r10_rst_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr && mode_i.rst_pos) |=> (ptr_q == '0));
  // R3: pointer only ever advances by one
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(pwr && mode_i.rst_pos)) |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1));
  // R3: no step without a tick
  a_r3_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !pwr) |=> $stable(ptr_q) && $stable(cnt_q));
endmodule

// File: rtl/wv_scale.sv
module wv_scale #(
  parameter int unsigned SAMPLE_W = wv_pkg::SAMPLE_W,
  parameter int unsigned VOL_W    = wv_pkg::VOL_W,
  localparam int unsigned PROD_W  = SAMPLE_W + VOL_W + 1
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [VOL_W-1:0]    vol_i,
  input  logic                en_i,
  output logic [SAMPLE_W-1:0] out_o
);
  logic signed [PROD_W-1:0] prod, shifted;

  assign prod    = $signed(sample_i) * $signed({1'b0, vol_i});
  assign shifted = prod >>> VOL_W;
  assign out_o   = en_i ? shifted[SAMPLE_W-1:0] : '0;
endmodule

// File: rtl/wave_voice.sv
module wave_voice
  import wv_pkg::*;
#(
  parameter int unsigned DEPTH  = WAVE_DEPTH,
  parameter int unsigned SW     = SAMPLE_W,
  parameter int unsigned PW     = PITCH_W,
  parameter int unsigned LW     = PITCH_LO_W,
  parameter int unsigned VW     = VOL_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          pitch_lo_we_i,
  input  logic          pitch_hi_we_i,
  input  logic [LW-1:0] pitch_data_i,
  input  logic          vol_we_i,
  input  logic [VW-1:0] vol_data_i,
  input  logic          enable_i,
  input  logic          freq8_i,
  input  logic          freq4_i,
  input  logic          rst_pos_i,
  input  logic          wave_we_i,
  input  logic [AW-1:0] wave_addr_i,
  input  logic [SW-1:0] wave_data_i,
  output logic [SW-1:0] sample_o,
  output logic [AW-1:0] pos_o
);
  wv_mode_t      mode;
  logic [AW-1:0] ptr_nxt;
  logic [SW-1:0] rd_sample, scaled, sample_q;
  logic [VW-1:0] vol_q;

  assign mode = '{freq8: freq8_i, freq4: freq4_i, rst_pos: rst_pos_i};

  wv_counter #(.PITCH_W(PW), .LO_W(LW), .PTR_W(AW), .MIN_PITCH(MIN_PITCH)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .pitch_lo_we_i, .pitch_hi_we_i, .pitch_data_i,
    .mode_i(mode), .ptr_o(pos_o), .ptr_nxt_o(ptr_nxt)
  );

  wv_table #(.DEPTH(DEPTH), .W(SW)) u_tab (
    .clk_i, .rst_ni, .we_i(wave_we_i), .waddr_i(wave_addr_i), .wdata_i(wave_data_i),
    .raddr_i(ptr_nxt), .rdata_o(rd_sample)
  );

  wv_scale #(.SAMPLE_W(SW), .VOL_W(VW)) u_scl (
    .sample_i(rd_sample), .vol_i(vol_q), .en_i(enable_i), .out_o(scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q    <= '0;
      sample_q <= '0;
    end else begin
      if (vol_we_i) vol_q    <= vol_data_i;
      if (tick_i)   sample_q <= scaled;
    end
  end

  assign sample_o = sample_q;

  // R9: disabled tick gives silence
  a_r9_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !enable_i) |=> (sample_o == '0));
  // R8: output only moves on a tick
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sample_o));
endmodule

// File: tb/sim_wave_voice.sv
module sim_wave_voice;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [11:0] pitch;
    logic        m8;
    logic        m4;
    logic [15:0] ticks;
    logic [4:0]  exp_pos;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{12'h009, 1'b0, 1'b0, 16'd1,   5'd1},  // R3 first tick steps
    '{12'h009, 1'b0, 1'b0, 16'd25,  5'd3},  // R3 period 10
    '{12'h014, 1'b0, 1'b0, 16'd43,  5'd3},  // R3 period 21
    '{12'h008, 1'b0, 1'b0, 16'd30,  5'd0},  // R4 pitch below 9
    '{12'h105, 1'b1, 1'b0, 16'd20,  5'd4},  // R5 low-byte carry
    '{12'h105, 1'b0, 1'b0, 16'd20,  5'd1},  // R3 same pitch, full counter
    '{12'h203, 1'b0, 1'b1, 16'd10,  5'd4},  // R6 split, nibble carry
    '{12'h203, 1'b1, 1'b1, 16'd10,  5'd3},  // R7 both modes
    '{12'h009, 1'b0, 1'b0, 16'd321, 5'd1}   // R3 wrap modulo 32
  };

  logic       clk = 0, rst_n = 0, tick = 0;
  logic       plo = 0, phi = 0, vwe = 0, en = 0, f8 = 0, f4 = 0, rpos = 0, wwe = 0;
  logic [7:0] pdata = 0, wdata = 0;
  logic [3:0] vdata = 0;
  logic [4:0] waddr = 0;
  logic [7:0] sample;
  logic [4:0] pos;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_voice u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pitch_lo_we_i(plo), .pitch_hi_we_i(phi),
    .pitch_data_i(pdata), .vol_we_i(vwe), .vol_data_i(vdata), .enable_i(en),
    .freq8_i(f8), .freq4_i(f4), .rst_pos_i(rpos), .wave_we_i(wwe), .wave_addr_i(waddr),
    .wave_data_i(wdata), .sample_o(sample), .pos_o(pos)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; f8 = 0; f4 = 0; rpos = 0; en = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic set_pitch(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); plo = 1; pdata = lo;
    @(negedge clk); plo = 0; phi = 1; pdata = hi;
    @(negedge clk); phi = 0;
  endtask

  task automatic wr_wave(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wwe = 1; waddr = a; wdata = d;
    @(negedge clk); wwe = 0;
  endtask

  task automatic set_vol(input logic [3:0] v);
    @(negedge clk); vwe = 1; vdata = v;
    @(negedge clk); vwe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pos", pos, 0);
    chk("R1 sample", sample, 0);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      f8 = VECS[v].m8; f4 = VECS[v].m4;
      set_pitch(VECS[v].pitch[7:0], {4'h0, VECS[v].pitch[11:8]});
      ticks(VECS[v].ticks);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", v), pos, VECS[v].exp_pos);
    end

    // R2: upper nibble of high data ignored -> pitch 0x009, period 10
    do_reset();
    set_pitch(8'h09, 8'hF0);
    ticks(21);
    chk("R2 high nibble ignored", pos, 3);

    // R8 / R9 / R11 output path
    do_reset();
    wr_wave(5'd1, 8'h80);
    wr_wave(5'd2, 8'h7F);
    wr_wave(5'd3, 8'hFF);
    set_vol(4'd15);
    en = 1;
    set_pitch(8'h09, 8'h00);
    ticks(1);
    chk("R8 pos", pos, 1);
    chk("R8 -128*15", $signed(sample), -120);
    ticks(10);
    chk("R8 127*15", $signed(sample), 119);
    repeat (3) @(negedge clk);
    chk("R8 hold between ticks", $signed(sample), 119);
    set_vol(4'd1);
    ticks(10);
    chk("R8 arithmetic shift", $signed(sample), -1);
    en = 0;
    ticks(1);
    chk("R9 disabled", sample, 0);
    wr_wave(5'd3, 8'h40);
    set_vol(4'd8);
    en = 1;
    ticks(1);
    chk("R11 rewritten entry pos", pos, 3);
    chk("R11 rewritten entry", $signed(sample), 32);

    // R10 reset-position
    do_reset();
    set_pitch(8'h09, 8'h00);
    ticks(25);
    chk("R10 setup", pos, 3);
    set_pitch(8'h09, 8'h00);
    chk("R10 no clear when mode off", pos, 3);
    rpos = 1;
    @(negedge clk); phi = 1; pdata = 8'h00;
    @(negedge clk); phi = 0;
    chk("R10 high write clears", pos, 0);
    ticks(25);
    @(negedge clk); plo = 1; pdata = 8'h09;
    @(negedge clk); plo = 0;
    chk("R10 low write clears", pos, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule